// File: doc/BRIEF.md
# Prescaled Reference-Match Timer

A 16-bit up-counting timer with a small register port. A prescaler divides the system clock by a programmable ratio from 1 to 256. A clock-source field can add a further divide by 16. Each prescaled tick advances the counter. When the counter equals the reference value on a tick, a sticky reference event is flagged. Optionally, the counter then restarts from zero.

Software controls the timer through one 16-bit mode word. That word holds the enable bit, clock source, restart choice, interrupt enable and prescale value. The pending events are read from an event byte and cleared by writing ones to it. The single interrupt line is high while the reference event is pending and its interrupt enable is set.

Top module: `ref_match_timer`

## Requirements
- R1: After reset, every register (mode, reference, capture, counter, event) reads zero and `irq` is low.
- R2: Registers are decoded by offset: mode at 0x00, reference at 0x04, capture at 0x08, counter at 0x0C, event byte at 0x11 (bit 0 capture flag, bit 1 reference flag). Mode, reference, capture and counter read back what was written. Any other offset reads zero.
- R3: With mode bit 0 set and clock source bits [2:1] = 1, the counter advances once every P+1 clocks, where P is mode bits [15:8].
- R4: With clock source bits [2:1] = 2, the counter advances once every 16*(P+1) clocks.
- R5: The counter holds its value while mode bit 0 is clear or the clock source is 0 or 3.
- R6: On a tick where the counter equals the reference, event bit 1 is set. If mode bit 3 (restart) is set, the counter goes to zero on that tick.
- R7: With restart clear, the counter continues past the reference and wraps from 0xFFFF to 0x0000.
- R8: Writing the event byte clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R9: `irq` equals mode bit 4 AND event bit 1.
- R10: A mode write with data bit 0 clear, while mode bit 0 is currently set, clears the reference to zero and stores the written mode value.
- R11: Any write to the mode or reference register restarts the prescale count, so the next tick comes a full divide period after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 1 | Reference-event interrupt |

## Verification
A wrong prescaler phase shows up as a counter value that is off by one when it is read at a multiple of the divide period. So the bench reads the counter at exact clock counts after each configuration write. A wrong reference or flag state shows at the first matching tick: the counter reads a nonzero value after restart, or the event byte and `irq` fail to rise in that same cycle. A lost or spurious flag clear is visible on the next read of the event byte.

// File: rtl/ref_match_timer.sv
module ref_match_timer #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 8,
  parameter int SLOW_DIV = 16,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  localparam int SLOW_W = $clog2(SLOW_DIV);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_REF  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_EV   = ADDR_W'(5'h11);

  logic [CNT_W-1:0]  mode_q, ref_q, cap_q, cnt_q;
  logic [1:0]        ev_q, ev_d;
  logic [PRE_W-1:0]  pre_q;
  logic [SLOW_W-1:0] slow_q;

  wire wr_mode = wr_en && addr == A_MODE;
  wire wr_ref  = wr_en && addr == A_REF;
  wire wr_cap  = wr_en && addr == A_CAP;
  wire wr_cnt  = wr_en && addr == A_CNT;
  wire wr_ev   = wr_en && addr == A_EV;
  wire cfg_wr  = wr_mode || wr_ref;

  wire [1:0] src      = mode_q[2:1];
  wire       run      = mode_q[0] && (src == 2'd1 || src == 2'd2);
  wire       pre_hit  = run && pre_q == mode_q[8 +: PRE_W];
  wire       slow_hit = slow_q == SLOW_W'(SLOW_DIV - 1);
  wire       tick     = pre_hit && (src == 2'd1 || slow_hit) && !cfg_wr && !wr_cnt;
  wire       match    = cnt_q == ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr || !run) begin
      pre_q  <= '0;
      slow_q <= '0;
    end else if (pre_hit) begin
      pre_q <= '0;
      if (src == 2'd2) slow_q <= slow_hit ? '0 : slow_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      ref_q  <= '0;
      cap_q  <= '0;
    end else begin
      if (wr_mode) begin
        mode_q <= wr_data;
        if (mode_q[0] && !wr_data[0]) ref_q <= '0;
      end
      if (wr_ref) ref_q <= wr_data;
      if (wr_cap) cap_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wr_data;
    else if (tick)   cnt_q <= (match && mode_q[3]) ? '0 : cnt_q + 1'b1;
  end

  always_comb begin
    ev_d = ev_q & ~(wr_ev ? wr_data[1:0] : 2'b00);
    if (tick && match) ev_d[1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= ev_d;
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_REF:   rd_data = ref_q;
      A_CAP:   rd_data = cap_q;
      A_CNT:   rd_data = cnt_q;
      A_EV:    rd_data = CNT_W'(ev_q);
      default: rd_data = '0;
    endcase
  end

  assign irq = mode_q[4] & ev_q[1];

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= mode_q[8 +: PRE_W]);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt_q));
  p_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> ev_q[1]);
  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match && mode_q[3]) |=> cnt_q == '0);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_q[1] && !(wr_ev && wr_data[1])) |=> ev_q[1]);
  p_disable_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && mode_q[0] && !wr_data[0]) |=> ref_q == '0);
endmodule

// File: tb/ref_match_timer_tb.sv
module ref_match_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {1'b0, 5'h04, 16'h1234, 16'h0000},
    {1'b1, 5'h04, 16'h0000, 16'h1234},
    {1'b0, 5'h08, 16'hBEEF, 16'h0000},
    {1'b1, 5'h08, 16'h0000, 16'hBEEF},
    {1'b0, 5'h0C, 16'h0055, 16'h0000},
    {1'b1, 5'h0C, 16'h0000, 16'h0055},
    {1'b1, 5'h10, 16'h0000, 16'h0000},
    {1'b1, 5'h11, 16'h0000, 16'h0000},
    {1'b0, 5'h00, 16'h0310, 16'h0000},
    {1'b1, 5'h00, 16'h0000, 16'h0310},
    {1'b1, 5'h02, 16'h0000, 16'h0000},
    {1'b1, 5'h1F, 16'h0000, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [4:0] addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  int checks = 0, fails = 0;

  ref_match_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                         .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: offset 0x%0h read 0x%0h expected 0x%0h", tag, a, rd_data, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s: irq %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk(5'h00, 16'h0000, "R1"); chk(5'h04, 16'h0000, "R1");
    chk(5'h08, 16'h0000, "R1"); chk(5'h0C, 16'h0000, "R1");
    chk(5'h11, 16'h0000, "R1"); chk_irq(1'b0, "R1");

    // R2 register map vectors
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][37]) chk(VEC[i][36:32], VEC[i][15:0], "R2");
      else            wr(VEC[i][36:32], VEC[i][31:16]);
    end

    // R3 source 1, prescale 3 -> divide by 4
    wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h0303);
    wait_n(40);
    chk(5'h0C, 16'd10, "R3");

    // R11 reference write restarts prescale
    wait_n(2);
    wr(5'h04, 16'hFFFF);
    wait_n(3);
    chk(5'h0C, 16'd10, "R11");
    wait_n(1);
    chk(5'h0C, 16'd11, "R11");

    // R4 source 2, prescale 0 -> divide by 16
    wr(5'h0C, 16'h0000);
    wr(5'h00, 16'h0005);
    wait_n(48);
    chk(5'h0C, 16'd3, "R4");

    // R6 match with restart and interrupt enable
    wr(5'h00, 16'h0000);
    wr(5'h0C, 16'h0000);
    wr(5'h04, 16'h0003);
    wr(5'h00, 16'h001B);
    wait_n(3);
    chk(5'h0C, 16'd3, "R6"); chk(5'h11, 16'h0000, "R6"); chk_irq(1'b0, "R9");
    wait_n(1);
    chk(5'h0C, 16'd0, "R6"); chk(5'h11, 16'h0002, "R6"); chk_irq(1'b1, "R9");

    // R5 source 0 freezes the counter
    wr(5'h00, 16'h0019);
    wait_n(10);
    chk(5'h0C, 16'd0, "R5");

    // R9 interrupt follows enable bit
    wr(5'h00, 16'h0009);
    chk_irq(1'b0, "R9");
    wr(5'h00, 16'h0019);
    chk_irq(1'b1, "R9");

    // R8 write-one-to-clear
    wr(5'h11, 16'h0000);
    chk(5'h11, 16'h0002, "R8");
    wr(5'h11, 16'h0001);
    chk(5'h11, 16'h0002, "R8");
    wr(5'h11, 16'h0002);
    chk(5'h11, 16'h0000, "R8"); chk_irq(1'b0, "R8");

    // R7 wrap without restart, counting past the reference
    wr(5'h00, 16'h0000);
    wr(5'h0C, 16'hFFFE);
    wr(5'h04, 16'h0010);
    wr(5'h00, 16'h0003);
    wait_n(2);
    chk(5'h0C, 16'h0000, "R7"); chk(5'h11, 16'h0000, "R7");
    wait_n(16);
    chk(5'h0C, 16'h0010, "R7"); chk(5'h11, 16'h0000, "R7");
    wait_n(1);
    chk(5'h0C, 16'h0011, "R7"); chk(5'h11, 16'h0002, "R7");

    // R10 enable 1->0 clears reference, stores new mode
    wr(5'h00, 16'h0300);
    chk(5'h00, 16'h0300, "R10"); chk(5'h04, 16'h0000, "R10");
    chk_irq(1'b0, "R9");
    wait_n(5);
    chk(5'h0C, 16'h0011, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule